// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the serial-side controller of a two-wire EEPROM. It filters the incoming clock and data lines, detects start and stop conditions and compares the first byte after a start with a device address made of a fixed prefix and three strap inputs. A write carries two word-address bytes and one data byte. Reads return bytes from an internal address counter, either at a freshly loaded address or at whatever address the counter holds.

A write that ends with a stop commits the byte to an internal synchronous RAM. It then opens a timed self-write window. During that window the controller does not answer on the bus. A write-protect input keeps the array unchanged while still letting the transaction complete on the wire.

The data line is open drain. The block only pulls it low through `sda_oe_o`, and the board or bench resolves the wired-AND.

Top module: `twi_eeprom_ctrl`

## Requirements
- R1: After a start, the byte {1,0,1,0, strap_i[2], strap_i[1], strap_i[0], rw} (most significant bit first) is acknowledged by holding `sda_oe_o` high during the ninth SCL high phase.
- R2: A first byte whose four top bits differ from 1010, or whose next three bits differ from `strap_i`, gets no acknowledge. `sda_oe_o` then stays low until the next start.
- R3: Bit 0 of the address byte picks the direction: 0 means write and 1 means read.
- R4: A write sends the high word-address byte, then the low word-address byte, then one data byte, and each gets an acknowledge. A stop after the data byte stores it at the low MEM_AW bits of the word address and advances the internal address by one.
- R5: After a committed write, the block ignores the bus and drives nothing for TWR_CYCLES system clocks. After that it again acknowledges a matching address.
- R6: While `wp_i` is high, the write bytes are still acknowledged, the array is left unchanged and no busy window starts.
- R7: A random read is a write-direction address phase with two address bytes, a repeated start and a read-direction address byte. Data is sent most significant bit first (`sda_oe_o` high for a 0 bit). The internal address increments after each byte, and a master acknowledge (SDA low) fetches the next byte.
- R8: A master no-acknowledge ends sending. A later read-direction address byte with no word address returns the byte at the current internal address.
- R9: Pulses shorter than FILT_LEN system clocks on SCL or SDA are not taken as clock edges, starts or stops.
- R10: During and right after reset, `sda_oe_o` is low.
- R11: `sda_oe_o` only starts driving while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, resolved bus level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| strap_i | input | 3 | Device address straps, tie low if unused |
| wp_i | input | 1 | Write protect for the whole array |

## Verification
Each input edge reaches the controller after two synchronizer flops plus FILT_LEN filter clocks. The drive change then appears one register later, so an acknowledge or data bit appears about seven clocks after the SCL falling edge that precedes it. The bench holds each SCL level for sixteen clocks. It compares `sda_oe_o` with the reference model on every clock of the second half of each SCL high phase, which lies well clear of that latency. The busy window is probed right after a stop, which is far inside TWR_CYCLES, and later accesses wait TWR_CYCLES plus a margin before they start.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK,
        ST_HOLD,
        ST_BUSY
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DAT
    } rx_phase_e;

    typedef struct packed {
        ctl_state_e st;
        rx_phase_e  ph;
        logic       rd;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ahi;
        logic [15:0] addr;
        logic [7:0] wdat;
        logic       oe;
        logic       mnack;
        logic       scl_p;
        logic       sda_p;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st:    ST_IDLE,
        ph:    PH_DEV,
        rd:    1'b0,
        cnt:   4'd0,
        sh:    8'd0,
        ahi:   8'd0,
        addr:  16'd0,
        wdat:  8'd0,
        oe:    1'b0,
        mnack: 1'b1,
        scl_p: 1'b1,
        sda_p: 1'b1
    };

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          sync1_q, sync2_q, filt_q, filt_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d  = '0;
        filt_d = filt_q;
        if (sync2_q != filt_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_d = sync2_q;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            filt_q  <= 1'b1;
            cnt_q   <= '0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            filt_q  <= filt_d;
            cnt_q   <= cnt_d;
        end
    end

    assign filt_o = filt_q;

    // R9: the filtered level only moves to a value the synchronizer held
    a_r9_accept_after_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_q != $past(filt_q)) |-> ($past(sync2_q) == filt_q && cnt_q == '0));

endmodule

// File: rtl/twi_write_timer.sv
module twi_write_timer #(
    parameter int TWR_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(TWR_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(TWR_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R5: a commit always opens the busy window on the next clock
    a_r5_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);

    // R5: the window shrinks one clock at a time
    a_r5_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/twi_eeprom_array.sv
module twi_eeprom_array #(
    parameter int MEM_AW = 8
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [MEM_AW-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [MEM_AW-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
    import twi_eeprom_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int FILT_LEN   = 4,
    parameter int TWR_CYCLES = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              scl_f, sda_f;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        twi_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    ctl_t       q, d;
    logic       commit;
    logic       wbusy;
    logic [7:0] rdata;
    logic       scl_rise, scl_fall, start_ev, stop_ev, dev_hit;

    assign scl_rise = scl_f & ~q.scl_p;
    assign scl_fall = ~scl_f & q.scl_p;
    assign start_ev = scl_f & q.scl_p & q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & q.scl_p & ~q.sda_p & sda_f;
    assign dev_hit  = (q.sh[7:4] == DEV_PREFIX) && (q.sh[3:1] == strap_i);

    always_comb begin
        d       = q;
        d.scl_p = scl_f;
        d.sda_p = sda_f;
        commit  = 1'b0;
        if (q.st == ST_BUSY) begin
            d.oe = 1'b0;
            if (!wbusy) d.st = ST_IDLE;
        end else if (start_ev) begin
            d.st  = ST_RECV;
            d.ph  = PH_DEV;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (stop_ev) begin
            d.oe = 1'b0;
            d.st = ST_IDLE;
            if (q.st == ST_HOLD && !wp_i) begin
                commit = 1'b1;
                d.st   = ST_BUSY;
                d.addr = q.addr + 16'd1;
            end
        end else begin
            case (q.st)
                ST_RECV: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_f};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        if (q.ph != PH_DEV || dev_hit) begin
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                            if (q.ph == PH_DEV) d.rd = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_RECV;
                        case (q.ph)
                            PH_DEV: begin
                                if (q.rd) begin
                                    d.st  = ST_SEND;
                                    d.sh  = rdata;
                                    d.oe  = ~rdata[7];
                                    d.cnt = 4'd0;
                                end else begin
                                    d.ph = PH_AHI;
                                end
                            end
                            PH_AHI: begin
                                d.ahi = q.sh;
                                d.ph  = PH_ALO;
                            end
                            PH_ALO: begin
                                d.addr = {q.ahi, q.sh};
                                d.ph   = PH_DAT;
                            end
                            default: begin
                                d.wdat = q.sh;
                                d.st   = ST_HOLD;
                            end
                        endcase
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.oe   = 1'b0;
                            d.st   = ST_MACK;
                            d.addr = q.addr + 16'd1;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mnack = sda_f;
                    end else if (scl_fall) begin
                        if (q.mnack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_SEND;
                            d.sh  = rdata;
                            d.oe  = ~rdata[7];
                            d.cnt = 4'd0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= CTL_RESET;
        else         q <= d;
    end

    twi_eeprom_array #(.MEM_AW(MEM_AW)) u_array (
        .clk_i   (clk_i),
        .we_i    (commit),
        .waddr_i (q.addr[MEM_AW-1:0]),
        .wdata_i (q.wdat),
        .raddr_i (q.addr[MEM_AW-1:0]),
        .rdata_o (rdata)
    );

    twi_write_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (commit),
        .busy_o  (wbusy)
    );

    assign sda_oe_o = q.oe;

    // R1 / R2: the address acknowledge only follows a matching first byte
    a_r1_ack_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_ACK && q.ph == PH_DEV) |->
        (q.sh[7:4] == 4'b1010 && q.sh[3:1] == strap_i));

    // R11: the line is only grabbed while the clock is low
    a_r11_grab_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> !scl_f);

    // R5: nothing is driven during the self-timed write
    a_r5_deaf_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wbusy |-> !sda_oe_o);

    // R6: the array is never written while protected
    a_r6_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit |-> !wp_i);

    // R4: a commit only ends a complete write sequence
    a_r4_commit_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit |-> (q.st == ST_HOLD));

endmodule

// File: tb/sim_twi_eeprom_ctrl.sv
module sim_twi_eeprom_ctrl;
    localparam int HALF     = 16;
    localparam int MEM_AW   = 8;
    localparam int FILT_LEN = 4;
    localparam int TWR      = 1000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic [2:0] strap;
    logic       wp;
    logic       sda_oe;
    logic       sda_line;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_eeprom_ctrl #(.MEM_AW(MEM_AW), .FILT_LEN(FILT_LEN), .TWR_CYCLES(TWR)) u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .wp_i     (wp)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] ref_mem [256];
    int         ref_addr = 0;
    bit         ref_busy = 0;
    bit         done = 0;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    function automatic logic dev_ack(input logic [7:0] v);
        return (v[7:4] == 4'b1010) && (v[3:1] == strap) && !ref_busy;
    endfunction

    // one SCL period, drive-enable compared every clock in the late high phase
    task automatic clk_bit(input logic b, input logic exp_oe, input string req,
                           input bit glitch, output logic seen);
        wclk(4);
        sda_m = b;
        if (glitch) begin
            wclk(3);
            scl_m = 1'b1;
            wclk(2);
            scl_m = 1'b0;
            wclk(HALF - 9);
        end else begin
            wclk(HALF - 4);
        end
        scl_m = 1'b1;
        wclk(HALF / 2);
        seen = sda_line;
        for (int i = 0; i < HALF / 2; i++) begin
            check(sda_oe == exp_oe, req, 16'(sda_oe), 16'(exp_oe));
            @(negedge clk);
        end
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wclk(4);
        sda_m = 1'b1;
        wclk(HALF);
        scl_m = 1'b1;
        wclk(HALF);
        sda_m = 1'b0;
        wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(4);
        sda_m = 1'b0;
        wclk(HALF);
        scl_m = 1'b1;
        wclk(HALF);
        sda_m = 1'b1;
        wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req, input bit glitch);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], 1'b0, req, glitch, s);
        clk_bit(1'b1, exp_ack, req, 1'b0, s);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit more, input string req);
        logic       s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, ~exp[i], req, 1'b0, s);
            got[i] = s;
        end
        clk_bit(more ? 1'b0 : 1'b1, 1'b0, req, 1'b0, s);
        check(got == exp, req, 16'(got), 16'(exp));
    endtask

    task automatic write_txn(input logic [15:0] a, input logic [7:0] v, input string req, input bit glitch);
        logic [7:0] db;
        db = dev_byte(strap, 1'b0);
        bus_start();
        send_byte(db, dev_ack(db), req, 1'b0);
        send_byte(a[15:8], 1'b1, req, glitch);
        send_byte(a[7:0], 1'b1, req, glitch);
        send_byte(v, 1'b1, req, 1'b0);
        bus_stop();
        if (!wp) begin
            ref_mem[a[7:0]] = v;
            ref_addr = (int'(a) + 1) & 8'hFF;
            ref_busy = 1;
        end
    endtask

    task automatic wait_ready();
        wclk(TWR + 50);
        ref_busy = 0;
    endtask

    task automatic random_read(input logic [15:0] a, input int n, input string req);
        bus_start();
        send_byte(dev_byte(strap, 1'b0), 1'b1, req, 1'b0);
        send_byte(a[15:8], 1'b1, req, 1'b0);
        send_byte(a[7:0], 1'b1, req, 1'b0);
        ref_addr = int'(a[7:0]);
        bus_start();
        send_byte(dev_byte(strap, 1'b1), 1'b1, req, 1'b0);
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_addr], k < n - 1, req);
            ref_addr = (ref_addr + 1) & 8'hFF;
        end
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string req);
        bus_start();
        send_byte(dev_byte(strap, 1'b1), 1'b1, req, 1'b0);
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_addr], k < n - 1, req);
            ref_addr = (ref_addr + 1) & 8'hFF;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        scl_m = 1'b1;
        sda_m = 1'b1;
        strap = 3'b101;
        wp    = 1'b0;
        wclk(5);
        check(sda_oe == 1'b0, "R10 in reset", 16'(sda_oe), 16'h0);
        rst_n = 1'b1;
        wclk(20);
        check(sda_oe == 1'b0, "R10 after reset", 16'(sda_oe), 16'h0);

        // R1 R3 R4: plain byte write
        write_txn(16'h0012, 8'hA5, "R4 write 0012", 1'b0);

        // R5: the device is deaf right after the commit
        bus_start();
        send_byte(dev_byte(strap, 1'b0), 1'b0, "R5 busy no ack", 1'b0);
        bus_stop();
        wait_ready();

        write_txn(16'h0013, 8'h3C, "R1 R4 write 0013", 1'b0);
        wait_ready();
        write_txn(16'h0014, 8'h7E, "R4 write 0014", 1'b0);
        wait_ready();
        write_txn(16'h0015, 8'h99, "R4 write 0015", 1'b0);
        wait_ready();

        // R7: random read with master acknowledge continuing
        random_read(16'h0012, 3, "R7 R3 sequential read");
        // R8: current-address read after a no-acknowledge
        cur_read(1, "R8 current read");

        // R4: upper word-address bits fold onto the array
        write_txn(16'h0130, 8'hC3, "R4 write 0130", 1'b0);
        wait_ready();
        random_read(16'h0030, 1, "R4 folded address");

        // R2: wrong strap, then the device stays silent on a following byte
        bus_start();
        send_byte(dev_byte(strap ^ 3'b001, 1'b0), 1'b0, "R2 strap mismatch", 1'b0);
        send_byte(8'h00, 1'b0, "R2 silent after mismatch", 1'b0);
        bus_stop();
        // R2: wrong prefix
        bus_start();
        send_byte({4'b1011, strap, 1'b1}, 1'b0, "R2 prefix mismatch", 1'b0);
        bus_stop();

        // R6: protected write is acknowledged, leaves data and opens no busy window
        wp = 1'b1;
        write_txn(16'h0012, 8'h00, "R6 protected write", 1'b0);
        random_read(16'h0012, 1, "R6 data unchanged and not busy");
        wp = 1'b0;

        // R9: short SDA dip while SCL high is not a start
        wclk(HALF);
        sda_m = 1'b0;
        wclk(2);
        sda_m = 1'b1;
        wclk(HALF);
        scl_m = 1'b0;
        send_byte(dev_byte(strap, 1'b0), 1'b0, "R9 glitch is no start", 1'b0);
        bus_stop();

        // R9: short SCL pulses inside bit low phases add no bits
        write_txn(16'h0040, 8'h5A, "R9 scl glitch write", 1'b1);
        wait_ready();
        random_read(16'h0040, 1, "R9 scl glitch readback");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule